// File: doc/BRIEF.md
# Programmable Reset Fan-out Delayer

This block takes one active-low platform reset and fans it out to three active-low reset outputs: slot, device and disk. Each output either tracks the input directly or, when its delay enable is set, holds low for a selectable time after the input rises. A platform reset that goes low reaches every output on the next clock, whatever the enables say. Each output can also be driven low for one pulse by a software request bit. The bit clears itself when the pulse ends, and the pulse width is the same shared delay selection that sets the release time.

A second path ANDs two power-good inputs into one power-good output. This path has its own enable, its own delay range and its own self-clearing pulse bit. A resume reset output stays low after the block reset and releases a fixed time later. All time is counted in ticks of a 1 ms enable. A prescaler divides the clock by a parameter to make this tick, so simulation can scale the ticks down. The control fields sit in two byte-wide registers. The surrounding register file writes them through a simple write port and reads them back on dedicated outputs.

Top module: `rst_fanout_delayer`

## Requirements
- R1: While the block reset is applied, the reset-control byte reads 0x03, the power-good control byte reads 0x07, and every output is low.
- R2: When the platform reset input is low at a clock edge, all three reset outputs are low after that edge, regardless of enable or software bits.
- R3: An output whose delay enable is 0 (slot = bit 2, device = bit 3, disk = bit 4 of the reset-control byte) goes high at the first clock edge after the input goes high, provided its software bit is clear.
- R4: An output whose delay enable is 1 goes high (sel+1)*RST_STEP ticks after the input rises, give or take one tick, where sel is bits 1:0 of the reset-control byte.
- R5: If the input drops while a release delay is counting, the count starts again from zero at the next rise.
- R6: Writing 1 to a software bit (slot = bit 5, device = bit 6, disk = bit 7) drives that output low for (sel+1)*RST_STEP ticks. The bit then clears to 0 by itself. Writing 0 to a pending bit does not cancel it, and the other outputs are unaffected.
- R7: The power-good output is low one clock after either power-good input is low.
- R8: With the power-good enable (bit 2) clear, the power-good output follows the AND of the inputs after one clock. With it set, the output rises (psel+1)*PG_STEP ticks after the AND rises, give or take one tick, where psel is bits 1:0.
- R9: Writing 1 to bit 7 of the power-good control byte drives the power-good output low for (psel+1)*PG_STEP ticks, after which the bit clears itself.
- R10: The resume reset output goes high RSM_TICKS ticks after the block reset is released, give or take one tick, and then stays high.
- R11: Bits 6:3 of the power-good control byte always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous block reset, active low; its release starts the resume timer |
| plat_rst_n | input | 1 | Platform reset input, active low |
| pg_in_a | input | 1 | First power-good input |
| pg_in_b | input | 1 | Second power-good input |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the reset-control byte, 1 the power-good control byte |
| wr_data | input | 8 | Register write data |
| slot_rst_n | output | 1 | Slot reset output, active low |
| dev_rst_n | output | 1 | Device reset output, active low |
| disk_rst_n | output | 1 | Disk reset output, active low |
| pg_out | output | 1 | Power-good output |
| resume_rst_n | output | 1 | Resume reset output, active low |
| rst_ctrl_q | output | 8 | Reset-control byte readback |
| pg_ctrl_q | output | 8 | Power-good control byte readback |

## Verification
The bench targets several corner cases, each with a mismatch it would show:
- Reset input dropping in the middle of a long release delay: a design that kept its count would release the output at least one tick early.
- Zero written to a pending software bit: a design that let the write clear the bit would end the pulse and show the bit as 0 on readback.
- The two delay selections and both paths checked in windows that do not overlap: an off-by-one select decode, or a power-good path that used the reset step, would release a full tick outside the window.
- Outputs without a delay: a design that delayed them anyway would fail the one-clock follow checks.

// File: rtl/rfd_pkg.sv
package rfd_pkg;
  localparam logic [7:0] RST_CTRL_INIT = 8'h03;
  localparam logic [7:0] PG_CTRL_INIT  = 8'h07;
  localparam int unsigned NUM_RST = 3;
  localparam int unsigned EN_LSB  = 2;
  localparam int unsigned SW_LSB  = 5;
  localparam int unsigned PG_EN_BIT = 2;
  localparam int unsigned PG_SW_BIT = 7;

  // Number of ticks for a 2-bit selection: (sel + 1) steps.
  function automatic int unsigned sel_to_ticks(input logic [1:0] sel, input int unsigned step);
    return (32'(sel) + 32'd1) * step;
  endfunction
endpackage

// File: rtl/rfd_tick_gen.sv
module rfd_tick_gen #(
  parameter int unsigned DIV = 200
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              div_cnt <= '0;
    else if (div_cnt == LAST) div_cnt <= '0;
    else                     div_cnt <= div_cnt + DW'(1);
  end

  assign tick = (div_cnt == LAST);
endmodule

// File: rtl/rfd_ctrl_regs.sv
module rfd_ctrl_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic [2:0] rst_sw_done,
  input  logic       pg_sw_done,
  output logic [1:0] rst_sel,
  output logic [2:0] rst_en,
  output logic [2:0] rst_sw,
  output logic [1:0] pg_sel,
  output logic       pg_en,
  output logic       pg_sw,
  output logic [7:0] rst_ctrl_q,
  output logic [7:0] pg_ctrl_q
);
  import rfd_pkg::*;

  logic [7:0] rst_q, pg_q;
  logic       wr_rst, wr_pg;

  assign wr_rst = wr_en && !wr_addr;
  assign wr_pg  = wr_en &&  wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= RST_CTRL_INIT;
    end else begin
      if (wr_rst) rst_q[4:0] <= wr_data[4:0];
      // software bits: write-one-to-set, cleared only by pulse completion
      rst_q[7:5] <= (rst_q[7:5] & ~rst_sw_done) | (wr_rst ? wr_data[7:5] : 3'b000);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= PG_CTRL_INIT;
    end else begin
      if (wr_pg) pg_q[2:0] <= wr_data[2:0];
      pg_q[6:3] <= 4'b0000;
      pg_q[7]   <= (pg_q[7] & ~pg_sw_done) | (wr_pg & wr_data[7]);
    end
  end

  assign rst_sel    = rst_q[1:0];
  assign rst_en     = rst_q[4:2];
  assign rst_sw     = rst_q[7:5];
  assign pg_sel     = pg_q[1:0];
  assign pg_en      = pg_q[PG_EN_BIT];
  assign pg_sw      = pg_q[PG_SW_BIT];
  assign rst_ctrl_q = rst_q;
  assign pg_ctrl_q  = pg_q;
endmodule

// File: rtl/rfd_delay_chan.sv
module rfd_delay_chan #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          src_n,
  input  logic          dly_en,
  input  logic          sw_req,
  input  logic [CW-1:0] limit,
  output logic          out_n,
  output logic          sw_done
);
  logic [CW-1:0] hold_cnt, pulse_cnt;
  logic          rel_q, released;

  // release timer: cleared whenever the source is low, so a reassertion restarts it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  hold_cnt <= '0;
    else if (!src_n)                             hold_cnt <= '0;
    else if (tick && !rel_q && hold_cnt < limit) hold_cnt <= hold_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 rel_q <= 1'b0;
    else if (!src_n)            rel_q <= 1'b0;
    else if (hold_cnt >= limit) rel_q <= 1'b1;
  end

  // software pulse timer runs while the request bit is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        pulse_cnt <= '0;
    else if (!sw_req)                  pulse_cnt <= '0;
    else if (tick && pulse_cnt < limit) pulse_cnt <= pulse_cnt + CW'(1);
  end

  assign sw_done  = sw_req && (pulse_cnt >= limit);
  assign released = src_n && (!dly_en || rel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_n <= 1'b0;
    else        out_n <= released && !sw_req;
  end
endmodule

// File: rtl/rfd_resume_gen.sv
module rfd_resume_gen #(
  parameter int unsigned TICKS = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic resume_n
);
  localparam int unsigned RW = $clog2(TICKS + 1);
  localparam logic [RW-1:0] LIM = RW'(TICKS);

  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_cnt <= '0;
    else if (tick && run_cnt < LIM) run_cnt <= run_cnt + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resume_n <= 1'b0;
    else        resume_n <= (run_cnt >= LIM);
  end
endmodule

// File: rtl/rst_fanout_delayer.sv
module rst_fanout_delayer #(
  parameter int unsigned TICK_DIV  = 200,
  parameter int unsigned RST_STEP  = 1,
  parameter int unsigned PG_STEP   = 100,
  parameter int unsigned RSM_TICKS = 66
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       plat_rst_n,
  input  logic       pg_in_a,
  input  logic       pg_in_b,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  output logic       slot_rst_n,
  output logic       dev_rst_n,
  output logic       disk_rst_n,
  output logic       pg_out,
  output logic       resume_rst_n,
  output logic [7:0] rst_ctrl_q,
  output logic [7:0] pg_ctrl_q
);
  import rfd_pkg::*;

  localparam int unsigned RSTW = $clog2(4 * RST_STEP + 1);
  localparam int unsigned PGW  = $clog2(4 * PG_STEP + 1);

  logic            ms_tick;
  logic [1:0]      rst_sel, pg_sel;
  logic [2:0]      rst_en, rst_sw, rst_sw_done;
  logic            pg_en, pg_sw, pg_sw_done;
  logic [RSTW-1:0] rst_limit;
  logic [PGW-1:0]  pg_limit;
  logic            pg_and;
  logic [2:0]      fan_out_n;

  rfd_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick)
  );

  rfd_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rst_sw_done(rst_sw_done), .pg_sw_done(pg_sw_done),
    .rst_sel(rst_sel), .rst_en(rst_en), .rst_sw(rst_sw),
    .pg_sel(pg_sel), .pg_en(pg_en), .pg_sw(pg_sw),
    .rst_ctrl_q(rst_ctrl_q), .pg_ctrl_q(pg_ctrl_q)
  );

  assign rst_limit = RSTW'(sel_to_ticks(rst_sel, RST_STEP));
  assign pg_limit  = PGW'(sel_to_ticks(pg_sel, PG_STEP));
  assign pg_and    = pg_in_a & pg_in_b;

  for (genvar g = 0; g < NUM_RST; g++) begin : g_rst_chan
    rfd_delay_chan #(.CW(RSTW)) u_chan (
      .clk(clk), .rst_n(rst_n), .tick(ms_tick),
      .src_n(plat_rst_n), .dly_en(rst_en[g]), .sw_req(rst_sw[g]),
      .limit(rst_limit), .out_n(fan_out_n[g]), .sw_done(rst_sw_done[g])
    );
  end

  rfd_delay_chan #(.CW(PGW)) u_pg_chan (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick),
    .src_n(pg_and), .dly_en(pg_en), .sw_req(pg_sw),
    .limit(pg_limit), .out_n(pg_out), .sw_done(pg_sw_done)
  );

  rfd_resume_gen #(.TICKS(RSM_TICKS)) u_resume (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .resume_n(resume_rst_n)
  );

  assign slot_rst_n = fan_out_n[0];
  assign dev_rst_n  = fan_out_n[1];
  assign disk_rst_n = fan_out_n[2];
endmodule

// File: rtl/rfd_checker.sv
module rfd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       plat_rst_n,
  input logic       pg_in_a,
  input logic       pg_in_b,
  input logic       slot_rst_n,
  input logic       dev_rst_n,
  input logic       disk_rst_n,
  input logic       pg_out,
  input logic       resume_rst_n,
  input logic [7:0] rst_ctrl_q,
  input logic [7:0] pg_ctrl_q
);
  assert_input_low_forces_outputs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !plat_rst_n |=> (!slot_rst_n && !dev_rst_n && !disk_rst_n));

  assert_undelayed_slot_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (plat_rst_n && !rst_ctrl_q[2] && !rst_ctrl_q[5]) |=> slot_rst_n);

  assert_sw_bit_holds_dev_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ctrl_q[6] |=> !dev_rst_n);

  assert_sw_bit_holds_disk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ctrl_q[7] |=> !disk_rst_n);

  assert_pg_needs_both_inputs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_in_a && pg_in_b) |=> !pg_out);

  assert_pg_sw_bit_holds_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pg_ctrl_q[7] |=> !pg_out);

  assert_resume_stays_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_rst_n |=> resume_rst_n);
endmodule

bind rst_fanout_delayer rfd_checker u_rfd_checker (
  .clk(clk), .rst_n(rst_n), .plat_rst_n(plat_rst_n),
  .pg_in_a(pg_in_a), .pg_in_b(pg_in_b),
  .slot_rst_n(slot_rst_n), .dev_rst_n(dev_rst_n), .disk_rst_n(disk_rst_n),
  .pg_out(pg_out), .resume_rst_n(resume_rst_n),
  .rst_ctrl_q(rst_ctrl_q), .pg_ctrl_q(pg_ctrl_q)
);

// File: tb/test_rst_fanout_delayer.sv
module test_rst_fanout_delayer;
  localparam int T   = 10;  // clocks per tick
  localparam int RST = 1;
  localparam int PGS = 5;
  localparam int RSM = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic plat_rst_n = 1'b0, pg_in_a = 1'b0, pg_in_b = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic slot_rst_n, dev_rst_n, disk_rst_n, pg_out, resume_rst_n;
  logic [7:0] rst_ctrl_q, pg_ctrl_q;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    int         at;
    int         sig;
    logic [7:0] exp;
    string      req;
  } sb_item_t;
  sb_item_t sb_q[$];

  rst_fanout_delayer #(.TICK_DIV(T), .RST_STEP(RST), .PG_STEP(PGS), .RSM_TICKS(RSM)) i_rst_fanout_delayer (
    .clk(clk), .rst_n(rst_n), .plat_rst_n(plat_rst_n),
    .pg_in_a(pg_in_a), .pg_in_b(pg_in_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .slot_rst_n(slot_rst_n), .dev_rst_n(dev_rst_n), .disk_rst_n(disk_rst_n),
    .pg_out(pg_out), .resume_rst_n(resume_rst_n),
    .rst_ctrl_q(rst_ctrl_q), .pg_ctrl_q(pg_ctrl_q)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // 0 slot, 1 dev, 2 disk, 3 pg, 4 resume, 5 reset-control byte, 6 pg byte
  function automatic logic [7:0] observe(input int s);
    case (s)
      0: return {7'b0, slot_rst_n};
      1: return {7'b0, dev_rst_n};
      2: return {7'b0, disk_rst_n};
      3: return {7'b0, pg_out};
      4: return {7'b0, resume_rst_n};
      5: return rst_ctrl_q;
      default: return pg_ctrl_q;
    endcase
  endfunction

  task automatic check_now(input int s, input logic [7:0] e, input string r);
    checks++;
    if (observe(s) !== e) begin
      fails++;
      $display("FAIL %s sig=%0d cycle=%0d actual=%h expected=%h", r, s, cyc, observe(s), e);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_at(input int dly, input int s, input logic [7:0] e, input string r);
    sb_item_t it;
    it.at = cyc + dly; it.sig = s; it.exp = e; it.req = r;
    sb_q.push_back(it);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].at == cyc) begin
        check_now(sb_q[i].sig, sb_q[i].exp, sb_q[i].req);
        sb_q.delete(i);
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic set_plat(input logic v);
    plat_rst_n = v;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check_now(5, 8'h03, "R1");
    check_now(6, 8'h07, "R1");
    check_now(0, 8'h00, "R1");
    check_now(3, 8'h00, "R1");
    check_now(4, 8'h00, "R1");
    rst_n = 1'b1;
    // R10: resume release window
    expect_at((RSM - 1) * T + 2, 4, 8'h00, "R10");
    expect_at(RSM * T + 3, 4, 8'h01, "R10");
    expect_at(RSM * T + 20, 4, 8'h01, "R10");
    repeat (3) @(negedge clk);

    // R3: no delay, follow; R2: drop
    expect_at(1, 0, 8'h01, "R3");
    expect_at(1, 1, 8'h01, "R3");
    expect_at(1, 2, 8'h01, "R3");
    set_plat(1'b1);
    repeat (5) @(negedge clk);
    expect_at(1, 0, 8'h00, "R2");
    expect_at(1, 2, 8'h00, "R2");
    set_plat(1'b0);
    repeat (3) @(negedge clk);

    // R4: slot and disk delayed, sel=01 (2 ticks)
    wr(1'b0, 8'h15);
    expect_at(1, 1, 8'h01, "R3");
    expect_at(T + 2, 0, 8'h00, "R4");
    expect_at(T + 2, 2, 8'h00, "R4");
    expect_at(2 * T + 2, 0, 8'h01, "R4");
    expect_at(2 * T + 2, 2, 8'h01, "R4");
    set_plat(1'b1);
    repeat (30) @(negedge clk);
    expect_at(1, 0, 8'h00, "R2");
    expect_at(1, 1, 8'h00, "R2");
    set_plat(1'b0);
    repeat (3) @(negedge clk);

    // R4: device delayed, sel=00 (1 tick)
    wr(1'b0, 8'h08);
    expect_at(1, 0, 8'h01, "R3");
    expect_at(2, 1, 8'h00, "R4");
    expect_at(T + 2, 1, 8'h01, "R4");
    set_plat(1'b1);
    repeat (20) @(negedge clk);
    set_plat(1'b0);
    repeat (3) @(negedge clk);

    // R5: slot delayed sel=11 (4 ticks), glitch restarts the count
    wr(1'b0, 8'h07);
    set_plat(1'b1);
    repeat (25) @(negedge clk);
    set_plat(1'b0);
    @(negedge clk);
    expect_at(3 * T + 2, 0, 8'h00, "R5");
    expect_at(4 * T + 2, 0, 8'h01, "R5");
    set_plat(1'b1);
    repeat (50) @(negedge clk);

    // R6: device software pulse, sel=01, zero write does not cancel
    wr(1'b0, 8'h01);
    repeat (3) @(negedge clk);
    expect_at(1, 5, 8'h41, "R6");
    expect_at(2, 1, 8'h00, "R6");
    expect_at(5, 0, 8'h01, "R6");
    expect_at(5, 2, 8'h01, "R6");
    expect_at(T + 3, 1, 8'h00, "R6");
    expect_at(2 * T + 3, 1, 8'h01, "R6");
    expect_at(2 * T + 3, 5, 8'h01, "R6");
    wr(1'b0, 8'h41);
    repeat (4) @(negedge clk);
    expect_at(1, 5, 8'h41, "R6");
    expect_at(2, 1, 8'h00, "R6");
    wr(1'b0, 8'h01);
    repeat (30) @(negedge clk);

    // R7 / R8: power-good delayed, psel=00 (5 ticks)
    wr(1'b1, 8'h04);
    pg_in_a = 1'b1;
    repeat (3) @(negedge clk);
    check_now(3, 8'h00, "R7");
    expect_at((PGS - 1) * T + 2, 3, 8'h00, "R8");
    expect_at(PGS * T + 2, 3, 8'h01, "R8");
    pg_in_b = 1'b1;
    repeat (60) @(negedge clk);
    expect_at(1, 3, 8'h00, "R7");
    pg_in_a = 1'b0;
    repeat (3) @(negedge clk);

    // R8: psel=01 (10 ticks)
    wr(1'b1, 8'h05);
    expect_at((2 * PGS - 1) * T + 2, 3, 8'h00, "R8");
    expect_at(2 * PGS * T + 2, 3, 8'h01, "R8");
    pg_in_a = 1'b1;
    repeat (110) @(negedge clk);

    // R8 follow with enable clear, R7 drop
    wr(1'b1, 8'h00);
    pg_in_a = 1'b0;
    repeat (3) @(negedge clk);
    expect_at(1, 3, 8'h01, "R8");
    pg_in_a = 1'b1;
    repeat (3) @(negedge clk);
    expect_at(1, 3, 8'h00, "R7");
    pg_in_b = 1'b0;
    repeat (3) @(negedge clk);
    expect_at(1, 3, 8'h01, "R8");
    pg_in_b = 1'b1;
    repeat (3) @(negedge clk);

    // R9: power-good software pulse, psel=00
    expect_at(1, 6, 8'h80, "R9");
    expect_at(2, 3, 8'h00, "R9");
    expect_at((PGS - 1) * T + 3, 3, 8'h00, "R9");
    expect_at(PGS * T + 3, 3, 8'h01, "R9");
    expect_at(PGS * T + 3, 6, 8'h00, "R9");
    wr(1'b1, 8'h80);
    repeat (60) @(negedge clk);

    // R11: reserved bits read zero
    expect_at(1, 6, 8'h07, "R11");
    wr(1'b1, 8'h7F);
    expect_at(1, 6, 8'h00, "R11");
    wr(1'b1, 8'h78);
    repeat (5) @(negedge clk);

    while (sb_q.size() != 0) @(negedge clk);
    finish_run();
  end
endmodule